// File: doc/BRIEF.md
# Temperature Sensor Sequencing Controller

This block sits between a host and an on-chip analog temperature sensor that only does single-shot conversions. The host sends one of four operation codes: switch the sensor on, switch it off, take a reading, or a reserved code. The block turns each code into the right sequence on three control lines to the analog core. These lines are an active-low reset, a power-down line and a run strobe. The block then returns one response carrying a status code and a signed 32-bit temperature.

To switch the sensor on, the block holds power-down for a short time and then lets the analog core power up with reset still held. It releases reset only after the full power-up wait and then lets the core settle. To take a reading, it strobes run with reset released and waits for a one-cycle done pulse from the sensor, up to a timeout. It then takes the 12-bit code out of the sensor status word and scales it to milli-degrees Celsius as code × 237500 / 4094 − 81100. Each operation truncates toward zero, in that order, and a sequential divider does the division.

Every delay is a cycle count that the block computes from a clock-frequency parameter, rounded up.

Top module: `tsense_seq_ctrl`

## Requirements
- R1: After reset the control lines read 3'b010 (bit 0 reset-release = 0, bit 1 power-down = 1, bit 2 run = 0). `req_ready` is 1, `rsp_valid` is 0 and `sensor_on` is 0.
- R2: An enable request (op 0) while off moves the control lines through three phases, and no other pattern appears.
  - 3'b010 for ceil(1 µs) cycles.
  - 3'b000 for ceil(60 µs) cycles.
  - 3'b001 for ceil(1 µs) cycles.
  - After the third phase the block answers status 0 (OK) and `sensor_on` becomes 1.
  - Reset-release never rises unless power-down was low for the whole power-up wait before it.
- R3: A measure request (op 2) while on drives 3'b101 for ceil(1 µs) cycles, then 3'b001. Run is never high unless reset-release is 1 and power-down is 0.
- R4: The raw code is bits 27:16 of `sns_status` at the done pulse; all other status bits have no effect. The response is status 0 with temperature code×237500/4094−81100, each step truncating.
- R5: If no done pulse comes during the run strobe or within ceil(10 ms) cycles after run falls, the response is status 2 (timeout) with temperature 0. The sensor stays on and later measurements work.
- R6: A measure request while off answers status 1 (no data) with temperature 0 on the next cycle. The control lines do not change.
- R7: A disable request (op 1) sets the control lines to 3'b010 and `sensor_on` to 0, answering status 0. A request that matches the current state answers status 0 and leaves the control lines untouched.
- R8: `req_ready` stays low from acceptance until the response is taken. While `rsp_valid` is high and `rsp_ready` is low, the status and temperature hold steady.
- R9: Reserved op 3 answers status 3 (bad operation) and changes neither the control lines nor `sensor_on`.
- R10: A done pulse that arrives while run is still high is kept and used for the result.
- R11: The temperature is two's-complement signed; code 0 gives −81100 and code 4095 gives 156458.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 enable, 1 disable, 2 measure, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_status | output | 2 | 0 OK, 1 no data, 2 timeout, 3 bad operation |
| rsp_temp | output | 32 | Signed milli-degrees Celsius, 0 unless status is OK after a measurement |
| sns_ctrl | output | 3 | bit 0 reset release, bit 1 power-down, bit 2 run |
| sns_status | input | 32 | Sensor status word, raw code in bits 27:16 |
| sns_done | input | 1 | One-cycle conversion-complete pulse |
| sensor_on | output | 1 | Sensor powered and released from reset |

## Verification
Two situations are hard to reach from the ports. One is a done pulse that lands while the run strobe is still high. The other is the full timeout window, with no done at all.

The bench models the sensor with a stub whose done latency is programmable, counted from the rising edge of run. A latency of zero puts the pulse inside the run strobe, and a negative latency withholds the pulse entirely. The bench sets the clock-frequency parameter low, so the 10 ms window is 20000 cycles and the exact length of every phase can be counted at the control lines.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

  typedef enum logic [1:0] {
    OP_ON     = 2'd0,
    OP_OFF    = 2'd1,
    OP_SAMPLE = 2'd2,
    OP_RSVD   = 2'd3
  } ts_op_e;

  typedef enum logic [1:0] {
    RS_OK      = 2'd0,
    RS_NODATA  = 2'd1,
    RS_TIMEOUT = 2'd2,
    RS_BADOP   = 2'd3
  } ts_rsp_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PD_HOLD,
    S_PWR_WAIT,
    S_SETTLE,
    S_RUN,
    S_CONV_WAIT,
    S_MUL,
    S_DIVIDE,
    S_RESP
  } ts_state_e;

  // control word bit roles: 0 reset release, 1 power-down, 2 run
  localparam logic [2:0] CTL_OFF  = 3'b010;
  localparam logic [2:0] CTL_DARK = 3'b000;
  localparam logic [2:0] CTL_LIVE = 3'b001;
  localparam logic [2:0] CTL_FIRE = 3'b101;

  // cycles needed to cover amount/per_second seconds, rounded up, at least 1
  function automatic longint ceil_cycles(longint amount, longint per_second, longint clk_hz);
    longint c;
    c = (amount * clk_hz + per_second - 1) / per_second;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/tsense_tick_timer.sv
module tsense_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/tsense_seqdiv.sv
// Restoring divider: one quotient bit per cycle, NUM_W cycles per result.
module tsense_seqdiv #(
  parameter int NUM_W = 30,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   diff;
  logic             fits;

  always_comb begin
    shifted = {rem_q, quo_q[NUM_W-1]};
    diff    = shifted - {1'b0, den};
    fits    = (shifted >= {1'b0, den});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= num;
        cnt_q <= CNT_W'(NUM_W);
      end else if (cnt_q != '0) begin
        rem_q <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
endmodule

// File: rtl/tsense_seq_ctrl.sv
module tsense_seq_ctrl
  import tsense_pkg::*;
#(
  parameter int CLK_HZ     = 200_000_000,
  parameter int PD_HOLD_NS = 1000,
  parameter int PWRUP_NS   = 60000,
  parameter int SETTLE_NS  = 1000,
  parameter int RUN_NS     = 1000,
  parameter int TIMEOUT_US = 10000,
  parameter int STAT_W     = 32,
  parameter int CODE_W     = 12,
  parameter int CODE_LSB   = 16,
  parameter int SCALE_NUM  = 237500,
  parameter int SCALE_DEN  = 4094,
  parameter int OFFSET     = 81100,
  parameter int RES_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_status,
  output logic [RES_W-1:0]  rsp_temp,
  output logic [2:0]        sns_ctrl,
  input  logic [STAT_W-1:0] sns_status,
  input  logic              sns_done,
  output logic              sensor_on
);
  localparam int PD_CYC  = int'(ceil_cycles(longint'(PD_HOLD_NS), 64'd1_000_000_000, longint'(CLK_HZ)));
  localparam int PU_CYC  = int'(ceil_cycles(longint'(PWRUP_NS),   64'd1_000_000_000, longint'(CLK_HZ)));
  localparam int SET_CYC = int'(ceil_cycles(longint'(SETTLE_NS),  64'd1_000_000_000, longint'(CLK_HZ)));
  localparam int RUN_CYC = int'(ceil_cycles(longint'(RUN_NS),     64'd1_000_000_000, longint'(CLK_HZ)));
  localparam int TO_CYC  = int'(ceil_cycles(longint'(TIMEOUT_US), 64'd1_000_000,     longint'(CLK_HZ)));
  localparam int MAX_A   = (PD_CYC > PU_CYC) ? PD_CYC : PU_CYC;
  localparam int MAX_B   = (SET_CYC > RUN_CYC) ? SET_CYC : RUN_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > TO_CYC) ? MAX_C : TO_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam int NUM_W   = CODE_W + $clog2(SCALE_NUM + 1);
  localparam int DEN_W   = $clog2(SCALE_DEN + 1);

  ts_state_e        state_q, state_d;
  logic             on_q, on_d;
  logic [2:0]       ctrl_q;
  logic             seen_q;
  logic [CODE_W-1:0] raw_q;
  ts_rsp_e          rsp_st_q, st_d;
  logic [RES_W-1:0] rsp_temp_q;

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             div_go;
  logic             div_done;
  logic [NUM_W-1:0] div_quo;
  logic [NUM_W-1:0] product;
  logic [RES_W-1:0] scaled;
  logic             live_phase;
  logic             stat_unused;

  assign stat_unused = ^{sns_status[STAT_W-1:CODE_LSB+CODE_W], sns_status[CODE_LSB-1:0]};

  function automatic logic [2:0] ctrl_of(ts_state_e s, logic on);
    case (s)
      S_PD_HOLD:                              return CTL_OFF;
      S_PWR_WAIT:                             return CTL_DARK;
      S_SETTLE, S_CONV_WAIT, S_MUL, S_DIVIDE: return CTL_LIVE;
      S_RUN:                                  return CTL_FIRE;
      default:                                return on ? CTL_LIVE : CTL_OFF;
    endcase
  endfunction

  tsense_tick_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign product = NUM_W'(raw_q) * NUM_W'(SCALE_NUM);

  tsense_seqdiv #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_go),
    .num   (product),
    .den   (DEN_W'(SCALE_DEN)),
    .done  (div_done),
    .quo   (div_quo)
  );

  assign scaled     = RES_W'(div_quo) - RES_W'(OFFSET);
  assign live_phase = (state_q == S_RUN) || (state_q == S_CONV_WAIT);

  always_comb begin
    state_d  = state_q;
    on_d     = on_q;
    st_d     = RS_OK;
    tmr_load = 1'b0;
    tmr_val  = '0;
    div_go   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          case (ts_op_e'(req_op))
            OP_ON: begin
              if (on_q) begin
                state_d = S_RESP;
              end else begin
                state_d  = S_PD_HOLD;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(PD_CYC - 1);
              end
            end
            OP_OFF: begin
              on_d    = 1'b0;
              state_d = S_RESP;
            end
            OP_SAMPLE: begin
              if (on_q) begin
                state_d  = S_RUN;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(RUN_CYC - 1);
              end else begin
                st_d    = RS_NODATA;
                state_d = S_RESP;
              end
            end
            default: begin
              st_d    = RS_BADOP;
              state_d = S_RESP;
            end
          endcase
        end
      end
      S_PD_HOLD: begin
        if (tmr_zero) begin
          state_d  = S_PWR_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(PU_CYC - 1);
        end
      end
      S_PWR_WAIT: begin
        if (tmr_zero) begin
          state_d  = S_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(SET_CYC - 1);
        end
      end
      S_SETTLE: begin
        if (tmr_zero) begin
          on_d    = 1'b1;
          state_d = S_RESP;
        end
      end
      S_RUN: begin
        if (tmr_zero) begin
          if (seen_q || sns_done) begin
            state_d = S_MUL;
          end else begin
            state_d  = S_CONV_WAIT;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(TO_CYC - 1);
          end
        end
      end
      S_CONV_WAIT: begin
        if (sns_done) begin
          state_d = S_MUL;
        end else if (tmr_zero) begin
          st_d    = RS_TIMEOUT;
          state_d = S_RESP;
        end
      end
      S_MUL: begin
        div_go  = 1'b1;
        state_d = S_DIVIDE;
      end
      S_DIVIDE: begin
        if (div_done) state_d = S_RESP;
      end
      S_RESP: begin
        if (rsp_ready) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      on_q       <= 1'b0;
      ctrl_q     <= CTL_OFF;
      seen_q     <= 1'b0;
      raw_q      <= '0;
      rsp_st_q   <= RS_OK;
      rsp_temp_q <= '0;
    end else begin
      state_q <= state_d;
      on_q    <= on_d;
      ctrl_q  <= ctrl_of(state_d, on_d);
      if (state_q == S_IDLE) begin
        seen_q <= 1'b0;
      end else if (live_phase && sns_done && !seen_q) begin
        seen_q <= 1'b1;
        raw_q  <= sns_status[CODE_LSB +: CODE_W];
      end
      if (state_d == S_RESP && state_q != S_RESP) begin
        rsp_st_q   <= st_d;
        rsp_temp_q <= (state_q == S_DIVIDE) ? scaled : '0;
      end
    end
  end

  assign req_ready  = (state_q == S_IDLE);
  assign rsp_valid  = (state_q == S_RESP);
  assign rsp_status = rsp_st_q;
  assign rsp_temp   = rsp_temp_q;
  assign sns_ctrl   = ctrl_q;
  assign sensor_on  = on_q;
endmodule

// File: rtl/tsense_seq_chk.sv
module tsense_seq_chk #(
  parameter int PU_CYC  = 1,
  parameter int RUN_CYC = 1,
  parameter int RES_W   = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       sns_ctrl,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [1:0]       rsp_status,
  input logic [RES_W-1:0] rsp_temp,
  input logic             sensor_on
);
  int dark_cnt;
  int fire_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dark_cnt <= 0;
      fire_cnt <= 0;
    end else begin
      if (sns_ctrl == 3'b000) dark_cnt <= (dark_cnt < 1_000_000_000) ? dark_cnt + 1 : dark_cnt;
      else                    dark_cnt <= 0;
      if (sns_ctrl[2])        fire_cnt <= (fire_cnt < 1_000_000_000) ? fire_cnt + 1 : fire_cnt;
      else                    fire_cnt <= 0;
    end
  end

  // R2: reset-release stays low whenever power-down is high
  a_r2_reset_held_while_down: assert property (@(posedge clk) disable iff (rst)
    sns_ctrl[1] |-> !sns_ctrl[0]);

  // R2: reset-release rises only after the full power-up wait with everything low
  a_r2_release_after_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(sns_ctrl[0]) |-> (dark_cnt >= PU_CYC));

  // R3: run only on a powered, released core
  a_r3_run_only_when_live: assert property (@(posedge clk) disable iff (rst)
    sns_ctrl[2] |-> (sns_ctrl[0] && !sns_ctrl[1]));

  // R3: the run strobe lasts exactly the computed width
  a_r3_run_width: assert property (@(posedge clk) disable iff (rst)
    $fell(sns_ctrl[2]) |-> (fire_cnt == RUN_CYC));

  // R6: no run strobe while the sensor is off
  a_r6_no_run_when_off: assert property (@(posedge clk) disable iff (rst)
    !sensor_on |-> !sns_ctrl[2]);

  // R8: busy while a response is pending
  a_r8_busy_excl: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && rsp_valid));

  // R8: response holds until taken
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_temp)));
endmodule

bind tsense_seq_ctrl tsense_seq_chk #(
  .PU_CYC  (PU_CYC),
  .RUN_CYC (RUN_CYC),
  .RES_W   (RES_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sns_ctrl   (sns_ctrl),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_status (rsp_status),
  .rsp_temp   (rsp_temp),
  .sensor_on  (sensor_on)
);

// File: tb/tb_tsense_seq_ctrl.sv
`timescale 1ns/1ps
module tb_tsense_seq_ctrl;
  // reduced frequency parameter: 1 us = 2, 60 us = 120, 10 ms = 20000 cycles
  localparam int TB_HZ   = 2_000_000;
  localparam int E_PD    = 2;
  localparam int E_PU    = 120;
  localparam int E_SET   = 2;
  localparam int E_RUN   = 2;
  localparam int E_TO    = 20000;
  localparam int VEC_N   = 7;
  localparam int V_RAW [VEC_N] = '{0, 1, 1397, 1398, 1400, 2048, 4095};
  localparam int V_LAT [VEC_N] = '{5, 0, 3, 1, 7, 2, 4};
  localparam int V_EXP [VEC_N] = '{-81100, -81042, -58, 0, 116, 37708, 156458};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_temp;
  logic [2:0]  sns_ctrl;
  logic [31:0] sns_status;
  logic        sns_done = 1'b0;
  logic        sensor_on;

  int n_chk = 0;
  int n_fail = 0;
  int hold_bad = 0;
  int stub_raw = 0;
  int stub_lat = 0;
  int stub_cnt = 0;
  bit stub_armed = 1'b0;
  bit prev_run = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign sns_status = {4'hF, stub_raw[11:0], 16'hFFFF};

  tsense_seq_ctrl #(.CLK_HZ(TB_HZ)) dut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_status (rsp_status),
    .rsp_temp   (rsp_temp),
    .sns_ctrl   (sns_ctrl),
    .sns_status (sns_status),
    .sns_done   (sns_done),
    .sensor_on  (sensor_on)
  );

  // analog core stub: done pulse stub_lat cycles after run rises, none if negative
  always @(negedge clk) begin
    sns_done = 1'b0;
    if (rst) begin
      stub_armed = 1'b0;
      prev_run   = 1'b0;
    end else begin
      if (sns_ctrl[2] && !prev_run) begin
        stub_cnt   = stub_lat;
        stub_armed = (stub_lat >= 0);
      end else if (stub_armed) begin
        if (stub_cnt == 0) begin
          sns_done   = 1'b1;
          stub_armed = 1'b0;
        end else begin
          stub_cnt = stub_cnt - 1;
        end
      end
      prev_run = sns_ctrl[2];
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_op(input logic [1:0] op, input int hold,
                        output int st, output int tmp,
                        output int c010, output int c000, output int c001,
                        output int c101, output int cx, output int waitn,
                        output bit order_ok);
    int idx;
    int last010;
    int first000;
    int last000;
    int first001;
    idx = 0; last010 = -1; first000 = -1; last000 = -1; first001 = -1;
    c010 = 0; c000 = 0; c001 = 0; c101 = 0; cx = 0;
    @(negedge clk);
    req_op = op;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    while (!rsp_valid && idx < 40000) begin
      case (sns_ctrl)
        3'b010: begin c010++; last010 = idx; end
        3'b000: begin c000++; last000 = idx; if (first000 < 0) first000 = idx; end
        3'b001: begin c001++; if (first001 < 0) first001 = idx; end
        3'b101: c101++;
        default: cx++;
      endcase
      idx++;
      @(negedge clk);
    end
    waitn = idx;
    st = int'(rsp_status);
    tmp = $signed(rsp_temp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (!(rsp_valid && !req_ready && int'(rsp_status) == st && $signed(rsp_temp) == tmp))
        hold_bad++;
    end
    order_ok = (first000 >= 0) && (last010 < first000) && (last000 < first001);
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    int st, tmp, c010, c000, c001, c101, cx, wn;
    bit ord;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sns_ctrl == 3'b010, "R1 ctrl", sns_ctrl, 2);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(sensor_on == 1'b0, "R1 sensor_on", sensor_on, 0);

    // R6 measure while off
    run_op(2'd2, 0, st, tmp, c010, c000, c001, c101, cx, wn, ord);
    chk(st == 1, "R6 status", st, 1);
    chk(tmp == 0, "R6 temp", tmp, 0);
    chk(wn == 0, "R6 latency", wn, 0);
    chk(sns_ctrl == 3'b010 && c101 == 0, "R6 ctrl untouched", sns_ctrl, 2);

    // R7 redundant disable while off
    run_op(2'd1, 0, st, tmp, c010, c000, c001, c101, cx, wn, ord);
    chk(st == 0 && sns_ctrl == 3'b010 && c010 == wn, "R7 redundant off", st, 0);

    // R9 reserved op
    run_op(2'd3, 0, st, tmp, c010, c000, c001, c101, cx, wn, ord);
    chk(st == 3, "R9 status", st, 3);
    chk(sns_ctrl == 3'b010 && sensor_on == 1'b0 && c010 == wn, "R9 no effect", sns_ctrl, 2);

    // R2 enable sequence
    run_op(2'd0, 0, st, tmp, c010, c000, c001, c101, cx, wn, ord);
    chk(c010 == E_PD, "R2 pd hold cycles", c010, E_PD);
    chk(c000 == E_PU, "R2 power-up cycles", c000, E_PU);
    chk(c001 == E_SET, "R2 settle cycles", c001, E_SET);
    chk(ord && c101 == 0 && cx == 0, "R2 order", ord, 1);
    chk(st == 0 && sensor_on == 1'b1, "R2 status/on", st, 0);

    // R7 redundant enable
    run_op(2'd0, 0, st, tmp, c010, c000, c001, c101, cx, wn, ord);
    chk(st == 0 && c001 == wn && sns_ctrl == 3'b001, "R7 redundant on", c001, wn);

    // R3 R4 R10 R11 vector table
    for (int v = 0; v < VEC_N; v++) begin
      stub_raw = V_RAW[v];
      stub_lat = V_LAT[v];
      run_op(2'd2, 0, st, tmp, c010, c000, c001, c101, cx, wn, ord);
      chk(st == 0, "R4 status", st, 0);
      chk(tmp == V_EXP[v], (V_LAT[v] == 0) ? "R10 done during run" : "R4 R11 temp", tmp, V_EXP[v]);
      chk(c101 == E_RUN && c010 == 0 && c000 == 0 && cx == 0, "R3 run strobe", c101, E_RUN);
    end

    // R8 busy and hold
    stub_raw = 1400;
    stub_lat = 3;
    hold_bad = 0;
    run_op(2'd2, 6, st, tmp, c010, c000, c001, c101, cx, wn, ord);
    chk(hold_bad == 0, "R8 hold stable", hold_bad, 0);
    chk(tmp == 116, "R8 temp", tmp, 116);
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R8 released", req_ready, 1);

    // R5 timeout
    stub_lat = -1;
    run_op(2'd2, 0, st, tmp, c010, c000, c001, c101, cx, wn, ord);
    chk(st == 2, "R5 status", st, 2);
    chk(tmp == 0, "R5 temp", tmp, 0);
    chk(c001 == E_TO, "R5 window", c001, E_TO);
    chk(sensor_on == 1'b1 && sns_ctrl == 3'b001, "R5 stays on", sensor_on, 1);
    stub_raw = 2048;
    stub_lat = 2;
    run_op(2'd2, 0, st, tmp, c010, c000, c001, c101, cx, wn, ord);
    chk(st == 0 && tmp == 37708, "R5 recovery", tmp, 37708);

    // R7 disable then R6 again
    run_op(2'd1, 0, st, tmp, c010, c000, c001, c101, cx, wn, ord);
    chk(st == 0 && sns_ctrl == 3'b010 && sensor_on == 1'b0, "R7 disable", sns_ctrl, 2);
    run_op(2'd2, 0, st, tmp, c010, c000, c001, c101, cx, wn, ord);
    chk(st == 1 && c101 == 0, "R6 after disable", st, 1);

    finished = 1'b1;
    summary();
  end
endmodule